// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a slave device is holding low. When it starts, it takes both pins away from the normal controller and drives them from its own state machine. It first releases both lines, then clocks SCL nine times with SDA released, and then forms a stop condition. After that it hands the pins back to the controller. The pins are open-drain: a value of 1 releases the line and 0 pulls it low. Every phase of the pattern lasts one interval of `HALF_CYC` functional-clock cycles. The default of 1250 cycles is 10 µs at 125 MHz.

A manual request on `kick_i` starts a run. An optional automatic trigger (`AUTO_EN`) is also available. It watches the bus-busy flag after each initialization attempt. If the bus stays busy for `BUSY_TMO` cycles, it starts one recovery run. When that run ends, it asks for initialization to be retried. Within one attempt the recovery runs at most once.

The sequencer states are:
- `SQ_IDLE`: pins belong to the controller.
- `SQ_PARK`: both lines released.
- `SQ_CLK_LO` and `SQ_CLK_HI`: the SCL pulses. `CLK_LO` always goes to `CLK_HI`. `CLK_HI` goes back to `CLK_LO` until the ninth pulse, and then goes to `SQ_STOP_LO`.
- `SQ_STOP_LO`: SDA low with SCL released.
- `SQ_STOP_HI`: both lines released, then back to `SQ_IDLE`.

Each state moves on when its interval ends. `SQ_IDLE` moves to `SQ_PARK` on a start request.

The automatic trigger has these states:
- `AW_IDLE`.
- `AW_WATCH`: counts busy cycles. It returns to `AW_IDLE` when the bus frees, or when the timeout expires after the one recovery has already been spent.
- `AW_RECOVER`: waits for the end of the run. It then goes back to `AW_WATCH` and pulses the retry output.

Top module: `i2c_unjam`

## Requirements
- R1: While reset is held, `busy_o`, `done_o` and `retry_o` are 0, and the pads follow the controller inputs.
- R2: While idle, `pad_scl_o` equals `ctl_scl_i` and `pad_sda_o` equals `ctl_sda_i`.
- R3: A start request sampled while idle raises `busy_o` in the next cycle. Both pads are then 1 (released) for `HALF_CYC` cycles.
- R4: SCL is then driven 0 for `HALF_CYC` cycles and 1 for `HALF_CYC` cycles, exactly nine times. SDA stays 1 throughout.
- R5: After the ninth pulse, SDA is 0 with SCL 1 for one interval, and then both are 1 for one interval.
- R6: While `busy_o` is 1, the pads ignore `ctl_scl_i` and `ctl_sda_i`. The whole override lasts 21 × `HALF_CYC` cycles.
- R7: `done_o` is 1 for exactly one cycle: the first cycle in which `busy_o` is 0 again. From that cycle the pads follow the controller.
- R8: A start request sampled while busy, including in the last override cycle, has no effect on the pattern or its length. A request sampled in the `done_o` cycle starts a new run.
- R9: After an `init_start_i` pulse, if `bus_busy_i` stays 1 for `BUSY_TMO` cycles, a run starts. `busy_o` rises `BUSY_TMO` cycles after the first watched cycle.
- R10: `retry_o` pulses together with `done_o` of an automatic run. If the bus stays busy after that, no second run starts within the same attempt.
- R11: If `bus_busy_i` falls before the timeout, no run starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kick_i | input | 1 | Manual start request |
| init_start_i | input | 1 | Pulse marking a new initialization attempt |
| bus_busy_i | input | 1 | Bus-busy flag from the controller |
| ctl_scl_i | input | 1 | Controller SCL drive (1 = release) |
| ctl_sda_i | input | 1 | Controller SDA drive (1 = release) |
| pad_scl_o | output | 1 | SCL pad drive (1 = release) |
| pad_sda_o | output | 1 | SDA pad drive (1 = release) |
| busy_o | output | 1 | Override active |
| done_o | output | 1 | One-cycle pulse when the pins are handed back |
| retry_o | output | 1 | Request to retry initialization after an automatic run |

## Verification
Two events can fall in the same cycle: a fresh start request and the end of a run. The bench drives `kick_i` in the final override cycle and again in the `done_o` cycle. The first request must leave the pattern and its length untouched. The second must start a new run in the very next cycle, with a full park interval. Random `kick_i` noise and random controller drive are applied during runs. Every override cycle is compared against a bench model of the pattern indexed by cycle offset.

// File: rtl/i2c_unjam_pkg.sv
package i2c_unjam_pkg;
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PARK,
        SQ_CLK_LO,
        SQ_CLK_HI,
        SQ_STOP_LO,
        SQ_STOP_HI
    } seq_state_e;

    typedef enum logic [1:0] {
        AW_IDLE,
        AW_WATCH,
        AW_RECOVER
    } watch_state_e;
endpackage

// File: rtl/i2c_unjam_timer.sv
module i2c_unjam_timer #(
    parameter int HALF_CYC = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_CYC < 2) ? 1 : $clog2(HALF_CYC);
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/i2c_unjam_fsm.sv
module i2c_unjam_fsm
    import i2c_unjam_pkg::*;
#(
    parameter int PULSES = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic busy,
    output logic done,
    output logic ovr_scl,
    output logic ovr_sda
);
    localparam int PW = $clog2(PULSES + 1);
    localparam logic [PW-1:0] PLAST = PW'(PULSES - 1);

    seq_state_e    state_q, state_d;
    logic [PW-1:0] pcnt_q;
    logic          done_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:    if (start) state_d = SQ_PARK;
            SQ_PARK:    if (tick)  state_d = SQ_CLK_LO;
            SQ_CLK_LO:  if (tick)  state_d = SQ_CLK_HI;
            SQ_CLK_HI:  if (tick)  state_d = (pcnt_q == PLAST) ? SQ_STOP_LO : SQ_CLK_LO;
            SQ_STOP_LO: if (tick)  state_d = SQ_STOP_HI;
            SQ_STOP_HI: if (tick)  state_d = SQ_IDLE;
            default:               state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            pcnt_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == SQ_STOP_HI) && tick;
            if (state_q == SQ_PARK)
                pcnt_q <= '0;
            else if (state_q == SQ_CLK_HI && tick)
                pcnt_q <= pcnt_q + 1'b1;
        end
    end

    always_comb begin
        busy    = 1'b1;
        ovr_scl = 1'b1;
        ovr_sda = 1'b1;
        unique case (state_q)
            SQ_IDLE:    busy    = 1'b0;
            SQ_PARK:    ;
            SQ_CLK_LO:  ovr_scl = 1'b0;
            SQ_CLK_HI:  ;
            SQ_STOP_LO: ovr_sda = 1'b0;
            SQ_STOP_HI: ;
            default:    busy    = 1'b0;
        endcase
    end

    assign done = done_q;
endmodule

// File: rtl/i2c_unjam_autotrig.sv
module i2c_unjam_autotrig
    import i2c_unjam_pkg::*;
#(
    parameter int BUSY_TMO = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init_start,
    input  logic bus_busy,
    input  logic seq_done,
    output logic req,
    output logic retry
);
    localparam int TW = (BUSY_TMO < 2) ? 1 : $clog2(BUSY_TMO);
    localparam logic [TW-1:0] TLAST = TW'(BUSY_TMO - 1);

    watch_state_e st_q, st_d;
    logic [TW-1:0] cnt_q, cnt_d;
    logic          spent_q, spent_d;
    logic          expired;

    assign expired = (cnt_q == TLAST);

    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        spent_d = spent_q;
        if (init_start) begin
            st_d    = AW_WATCH;
            cnt_d   = '0;
            spent_d = 1'b0;
        end else begin
            unique case (st_q)
                AW_IDLE: ;
                AW_WATCH: begin
                    if (!bus_busy)
                        st_d = AW_IDLE;
                    else if (expired) begin
                        st_d    = spent_q ? AW_IDLE : AW_RECOVER;
                        spent_d = 1'b1;
                    end else
                        cnt_d = cnt_q + 1'b1;
                end
                AW_RECOVER: begin
                    if (seq_done) begin
                        st_d  = AW_WATCH;
                        cnt_d = '0;
                    end
                end
                default: st_d = AW_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= AW_IDLE;
            cnt_q   <= '0;
            spent_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            spent_q <= spent_d;
        end
    end

    always_comb begin
        req   = (st_q == AW_WATCH) && bus_busy && expired && !spent_q && !init_start;
        retry = (st_q == AW_RECOVER) && seq_done;
    end
endmodule

// File: rtl/i2c_unjam.sv
module i2c_unjam #(
    parameter int HALF_CYC = 1250,
    parameter int PULSES   = 9,
    parameter int BUSY_TMO = 3000,
    parameter bit AUTO_EN  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_i,
    input  logic init_start_i,
    input  logic bus_busy_i,
    input  logic ctl_scl_i,
    input  logic ctl_sda_i,
    output logic pad_scl_o,
    output logic pad_sda_o,
    output logic busy_o,
    output logic done_o,
    output logic retry_o
);
    localparam int LANES = 2;

    logic             tick;
    logic             auto_req;
    logic             seq_start;
    logic [LANES-1:0] ctl_v, ovr_v, pad_v;

    assign seq_start = kick_i | auto_req;

    i2c_unjam_timer #(.HALF_CYC(HALF_CYC)) timer_i (
        .clk(clk), .rst_n(rst_n), .run(busy_o), .tick(tick)
    );

    i2c_unjam_fsm #(.PULSES(PULSES)) fsm_i (
        .clk(clk), .rst_n(rst_n), .start(seq_start), .tick(tick),
        .busy(busy_o), .done(done_o), .ovr_scl(ovr_v[0]), .ovr_sda(ovr_v[1])
    );

    generate
        if (AUTO_EN) begin : g_auto
            i2c_unjam_autotrig #(.BUSY_TMO(BUSY_TMO)) auto_i (
                .clk(clk), .rst_n(rst_n), .init_start(init_start_i),
                .bus_busy(bus_busy_i), .seq_done(done_o),
                .req(auto_req), .retry(retry_o)
            );
        end else begin : g_manual
            assign auto_req = 1'b0;
            assign retry_o  = 1'b0;
        end
    endgenerate

    assign ctl_v = {ctl_sda_i, ctl_scl_i};

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign pad_v[i] = busy_o ? ovr_v[i] : ctl_v[i];
        end
    endgenerate

    assign pad_scl_o = pad_v[0];
    assign pad_sda_o = pad_v[1];
endmodule

// File: rtl/i2c_unjam_chk.sv
module i2c_unjam_chk (
    input logic clk,
    input logic rst_n,
    input logic seq_start,
    input logic ctl_scl_i,
    input logic ctl_sda_i,
    input logic pad_scl_o,
    input logic pad_sda_o,
    input logic busy_o,
    input logic done_o,
    input logic retry_o
);
    // R2
    idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (pad_scl_o == ctl_scl_i) && (pad_sda_o == ctl_sda_i));

    // R3
    park_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> pad_scl_o && pad_sda_o);

    // R4
    sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && (pad_scl_o != $past(pad_scl_o))) |-> pad_sda_o);

    // R5
    stop_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !pad_sda_o) |-> pad_scl_o);

    // R7
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(seq_start));

    // R10
    retry_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retry_o |-> done_o);
endmodule

bind i2c_unjam i2c_unjam_chk chk_i (
    .clk(clk), .rst_n(rst_n), .seq_start(seq_start),
    .ctl_scl_i(ctl_scl_i), .ctl_sda_i(ctl_sda_i),
    .pad_scl_o(pad_scl_o), .pad_sda_o(pad_sda_o),
    .busy_o(busy_o), .done_o(done_o), .retry_o(retry_o)
);

// File: tb/i2c_unjam_tb_top.sv
`timescale 1ns/1ps
module i2c_unjam_tb_top;
    localparam int H     = 4;
    localparam int NP    = 9;
    localparam int TMO   = 20;
    localparam int TOTAL = (2 * NP + 3) * H;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic kick_i = 1'b0, init_start_i = 1'b0, bus_busy_i = 1'b0;
    logic ctl_scl_i = 1'b1, ctl_sda_i = 1'b1;
    logic pad_scl_o, pad_sda_o, busy_o, done_o, retry_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    i2c_unjam #(.HALF_CYC(H), .PULSES(NP), .BUSY_TMO(TMO), .AUTO_EN(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .kick_i(kick_i), .init_start_i(init_start_i),
        .bus_busy_i(bus_busy_i), .ctl_scl_i(ctl_scl_i), .ctl_sda_i(ctl_sda_i),
        .pad_scl_o(pad_scl_o), .pad_sda_o(pad_sda_o), .busy_o(busy_o),
        .done_o(done_o), .retry_o(retry_o)
    );

    function automatic bit exp_scl(int k);
        int ph = k / H;
        if (ph >= 1 && ph <= 2 * NP) return (ph % 2 == 0);
        return 1'b1;
    endfunction

    function automatic bit exp_sda(int k);
        int ph = k / H;
        return (ph == 2 * NP + 1) ? 1'b0 : 1'b1;
    endfunction

    function automatic string tag_of(int k);
        int ph = k / H;
        if (ph == 0) return "R3";
        if (ph <= 2 * NP) return "R4";
        return "R5";
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(bit kick, bit init, bit bbusy, bit cscl, bit csda);
        @(posedge clk);
        #2;
        kick_i = kick; init_start_i = init; bus_busy_i = bbusy;
        ctl_scl_i = cscl; ctl_sda_i = csda;
        @(negedge clk);
    endtask

    task automatic idle_check(string req);
        chk(busy_o == 1'b0, req, busy_o, 0);
        chk(pad_scl_o == ctl_scl_i && pad_sda_o == ctl_sda_i, req,
            {pad_sda_o, pad_scl_o}, {ctl_sda_i, ctl_scl_i});
    endtask

    // Checks override cycles kstart..TOTAL-1, then the done cycle.
    task automatic run_body(int kstart, bit noisy, bit last_kick, bit done_kick,
                            bit bbusy, bit exp_retry);
        for (int k = kstart; k < TOTAL; k++) begin
            bit kk = noisy ? 1'($urandom % 2) : 1'b0;
            if (k == TOTAL - 1) kk = last_kick;
            cyc(kk, 1'b0, bbusy, 1'($urandom % 2), 1'($urandom % 2));
            chk(busy_o == 1'b1, "R6", busy_o, 1);
            chk(pad_scl_o == exp_scl(k), tag_of(k), pad_scl_o, exp_scl(k));
            chk(pad_sda_o == exp_sda(k), tag_of(k), pad_sda_o, exp_sda(k));
        end
        cyc(done_kick, 1'b0, bbusy, 1'($urandom % 2), 1'($urandom % 2));
        chk(done_o == 1'b1, "R7", done_o, 1);
        idle_check("R7");
        chk(retry_o == exp_retry, "R10", retry_o, exp_retry);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        // R1: reset state
        repeat (3) cyc(1'b1, 1'b0, 1'b0, 1'($urandom % 2), 1'($urandom % 2));
        chk(busy_o == 1'b0 && done_o == 1'b0 && retry_o == 1'b0, "R1",
            {busy_o, done_o, retry_o}, 0);
        chk(pad_scl_o == ctl_scl_i && pad_sda_o == ctl_sda_i, "R1",
            {pad_sda_o, pad_scl_o}, {ctl_sda_i, ctl_scl_i});
        kick_i = 1'b0;
        rst_n = 1'b1;

        // R2: passthrough while idle
        for (int i = 0; i < 16; i++) begin
            cyc(1'b0, 1'b0, 1'b0, 1'($urandom % 2), 1'($urandom % 2));
            idle_check("R2");
        end

        // R3..R7: clean manual run
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        chk(busy_o == 1'b0, "R3", busy_o, 0);
        run_body(0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk(done_o == 1'b0, "R7", done_o, 1'b0);
        idle_check("R7");

        // R8: noisy kicks, kick in last cycle ignored, kick in done cycle restarts
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        run_body(0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        run_body(0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        chk(busy_o == 1'b0 && done_o == 1'b0, "R8", {busy_o, done_o}, 0);

        // Random mix of manual runs and idle gaps
        for (int r = 0; r < 4; r++) begin
            int gap = 1 + int'($urandom % 8);
            for (int g = 0; g < gap; g++) begin
                cyc(1'b0, 1'b0, 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
                idle_check("R2");
            end
            cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
            run_body(0, 1'($urandom % 2), 1'($urandom % 2), 1'b0, 1'b0, 1'b0);
        end

        // R9/R10: automatic trigger with bus stuck busy
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        for (int j = 0; j < TMO; j++) begin
            cyc(1'b0, 1'b0, 1'b1, 1'($urandom % 2), 1'($urandom % 2));
            chk(busy_o == 1'b0, "R9", busy_o, 0);
        end
        run_body(0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        for (int j = 0; j < 3 * TMO; j++) begin
            cyc(1'b0, 1'b0, 1'b1, 1'($urandom % 2), 1'($urandom % 2));
            chk(busy_o == 1'b0 && retry_o == 1'b0, "R10", {busy_o, retry_o}, 0);
        end

        // R11: bus frees before timeout
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        for (int j = 0; j < TMO / 2; j++)
            cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        for (int j = 0; j < 3 * TMO; j++) begin
            cyc(1'b0, 1'b0, 1'b1, 1'($urandom % 2), 1'($urandom % 2));
            chk(busy_o == 1'b0, "R11", busy_o, 0);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule